// File: doc/BRIEF.md
# SPI Master with Slave-Ready Gating

This block is a serial peripheral interface master. A host writes a transmit word through a simple parallel write port. The master then generates the serial clock, shifts the word out on MOSI, and captures MISO into a receive register that the host reads after the word ends. The clock polarity, clock phase, word length (2 to 16 bits), bit order and clock divider are programmable. The master can also drive an active-low chip select for the length of each word.

An optional ready input, active low, lets a slow slave control the pace of the bus. When the handshake is enabled, a queued word is not started until the synchronized ready input shows the slave is ready. The master therefore never needs a fixed worst-case gap between words. A single holding slot lets the host queue the next word while the current one is still shifting.

Top module: `spi_hs_master`

## Requirements
- R1: After reset, busy, done, rx_full and tx_held are 0, cs_n is 1, and sclk equals cfg_cpol.
- R2: With cfg_cpha=0, MISO is captured on the leading sclk edge of each bit and MOSI changes on the trailing edge. With cfg_cpha=1, MOSI changes on the leading edge and MISO is captured on the trailing edge. The leading edge is the edge that moves sclk away from cfg_cpol. All four polarity/phase pairs transfer data correctly.
- R3: sclk holds the cfg_cpol level whenever busy is 0. Each sclk half period lasts cfg_div+1 clock cycles, so busy stays high for exactly 2*L*(cfg_div+1) cycles per word of L bits.
- R4: The word length L is taken from cfg_len. A value below 2 gives 2 and a value above 16 gives 16. rx_data holds the L received bits right-justified, with the upper bits zero. Only the low L bits of wr_data are sent.
- R5: With cfg_lsb_first=0 the word is sent MSB first (bit L-1 first). With cfg_lsb_first=1 it is sent starting with bit 0. Received bits are placed with the same ordering.
- R6: With cfg_hs_en=1, a queued word does not start while rdy_n is high. rdy_n passes through a two-flop synchronizer, so after rdy_n falls, busy rises on the third rising clock edge.
- R7: With cfg_hs_en=0, rdy_n has no effect on when words start.
- R8: On the edge that ends a word, done is high for exactly one cycle, rx_full is set, and rx_data is updated. A rd_en pulse clears rx_full. If a word ends in the same cycle as rd_en, setting rx_full takes priority.
- R9: A word written while a transfer runs is held (tx_held=1) and sent next. A second write before that word starts replaces the held word.
- R10: With cfg_cs_en=1, cs_n is low for exactly the cycles in which busy is high. With cfg_cs_en=0, cs_n stays high.
- R11: With the handshake off and the master idle, a word written on clock edge w makes busy high after edge w+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | Idle level of sclk |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_lsb_first | input | 1 | 1 = send LSB first |
| cfg_hs_en | input | 1 | Enable ready-handshake gating |
| cfg_cs_en | input | 1 | Enable chip-select drive |
| cfg_div | input | DIV_W | sclk half period minus one, in clk cycles |
| cfg_len | input | LEN_W | Word length in bits (clamped to 2..16) |
| wr_en | input | 1 | Write strobe for transmit word |
| wr_data | input | WORD | Transmit word |
| rd_en | input | 1 | Acknowledge read, clears rx_full |
| rx_data | output | WORD | Last received word, right-justified |
| rx_full | output | 1 | Unread received word present |
| done | output | 1 | One-cycle end-of-word pulse |
| busy | output | 1 | Transfer in progress |
| tx_held | output | 1 | A word is waiting to start |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |
| rdy_n | input | 1 | Active-low slave-ready input |

## Verification
Each result has a fixed due cycle. busy rises one edge after a write, or three edges after rdy_n falls when the handshake gates the start. done and rx_data arrive exactly 2*L*(cfg_div+1) cycles after busy rises. The bench samples on falling clock edges. It counts the cycles busy stays high and compares that count with this formula. It checks the handshake latency edge by edge. A scoreboard queue holds each word's expected transmit and receive values, and a behavioural slave compares them when done pulses.

// File: rtl/spi_hs_pkg.sv
package spi_hs_pkg;
  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } spi_state_e;
endpackage

// File: rtl/spi_hs_sync.sv
module spi_hs_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_hs_baud.sv
module spi_hs_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_hs_shift.sv
module spi_hs_shift #(
  parameter int WORD  = 16,
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WORD-1:0]  load_data,
  input  logic             lsb_first,
  input  logic [LEN_W-1:0] len,
  input  logic             shift_out,
  input  logic             sample_in,
  input  logic             miso,
  output logic             mosi_bit,
  output logic [WORD-1:0]  rx_word
);
  logic [WORD-1:0] tx_sr;
  logic [WORD-1:0] rx_sr;
  logic [WORD-1:0] rx_nx;
  logic [LEN_W:0]  pad;

  assign pad = (LEN_W+1)'(WORD) - {1'b0, len};

  always_comb begin
    rx_nx = rx_sr;
    if (sample_in) begin
      if (lsb_first) rx_nx = {miso, rx_sr[WORD-1:1]};
      else           rx_nx = {rx_sr[WORD-2:0], miso};
    end
  end

  assign rx_word  = lsb_first ? (rx_nx >> pad) : rx_nx;
  assign mosi_bit = lsb_first ? tx_sr[0] : tx_sr[WORD-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr <= '0;
      rx_sr <= '0;
    end else if (load) begin
      tx_sr <= lsb_first ? load_data : (load_data << pad);
      rx_sr <= '0;
    end else begin
      if (shift_out) tx_sr <= lsb_first ? (tx_sr >> 1) : (tx_sr << 1);
      rx_sr <= rx_nx;
    end
  end
endmodule

// File: rtl/spi_hs_master.sv
module spi_hs_master
  import spi_hs_pkg::*;
#(
  parameter int WORD  = 16,
  parameter int DIV_W = 8,
  parameter int SYNC  = 2,
  parameter int LEN_W = $clog2(WORD + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic             cfg_lsb_first,
  input  logic             cfg_hs_en,
  input  logic             cfg_cs_en,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             wr_en,
  input  logic [WORD-1:0]  wr_data,
  input  logic             rd_en,
  output logic [WORD-1:0]  rx_data,
  output logic             rx_full,
  output logic             done,
  output logic             busy,
  output logic             tx_held,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             cs_n,
  input  logic             rdy_n
);
  localparam int ECNT_W = LEN_W + 1;

  spi_state_e       state;
  logic             pend_valid;
  logic [WORD-1:0]  pend_data;
  logic             cpha_l, lsb_l;
  logic [DIV_W-1:0] div_l;
  logic [LEN_W-1:0] len_l;
  logic [ECNT_W-1:0] edge_cnt;
  logic             sclk_r, cs_n_r, busy_r, done_r, rx_full_r;
  logic [WORD-1:0]  rx_data_r;

  logic             rdy_n_s;
  logic [LEN_W-1:0] len_eff;
  logic             start, tick, leading, last_edge;
  logic             do_sample, do_shift;
  logic             shf_lsb;
  logic [LEN_W-1:0] shf_len;
  logic [WORD-1:0]  rx_word;
  logic             mosi_bit;

  spi_hs_sync #(.STAGES(SYNC), .RST_VAL(1'b1)) u_rdy_sync (
    .clk(clk), .rst(rst), .d(rdy_n), .q(rdy_n_s)
  );

  always_comb begin
    if (cfg_len < LEN_W'(2))         len_eff = LEN_W'(2);
    else if (cfg_len > LEN_W'(WORD)) len_eff = LEN_W'(WORD);
    else                             len_eff = cfg_len;
  end

  assign start     = (state == ST_IDLE) && pend_valid && (!cfg_hs_en || !rdy_n_s);
  assign leading   = ~edge_cnt[0];
  assign last_edge = (edge_cnt == ({1'b0, len_l} << 1) - ECNT_W'(1));
  assign do_sample = tick && (cpha_l ? !leading : leading);
  assign do_shift  = tick && (cpha_l ? (leading && edge_cnt != '0) : !leading);
  assign shf_lsb   = (state == ST_IDLE) ? cfg_lsb_first : lsb_l;
  assign shf_len   = (state == ST_IDLE) ? len_eff : len_l;

  spi_hs_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .run(state == ST_SHIFT), .div(div_l), .tick(tick)
  );

  spi_hs_shift #(.WORD(WORD), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst(rst), .load(start), .load_data(pend_data),
    .lsb_first(shf_lsb), .len(shf_len), .shift_out(do_shift),
    .sample_in(do_sample), .miso(miso), .mosi_bit(mosi_bit), .rx_word(rx_word)
  );

  // holding slot: a fresh write wins over the slot being consumed
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid <= 1'b0;
      pend_data  <= '0;
    end else if (wr_en) begin
      pend_valid <= 1'b1;
      pend_data  <= wr_data;
    end else if (start) begin
      pend_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cpha_l    <= 1'b0;
      lsb_l     <= 1'b0;
      div_l     <= '0;
      len_l     <= LEN_W'(2);
      edge_cnt  <= '0;
      sclk_r    <= cfg_cpol;
      cs_n_r    <= 1'b1;
      busy_r    <= 1'b0;
      done_r    <= 1'b0;
      rx_full_r <= 1'b0;
      rx_data_r <= '0;
    end else begin
      done_r <= 1'b0;
      if (rd_en) rx_full_r <= 1'b0;
      case (state)
        ST_IDLE: begin
          sclk_r <= cfg_cpol;
          cs_n_r <= 1'b1;
          if (start) begin
            state    <= ST_SHIFT;
            cpha_l   <= cfg_cpha;
            lsb_l    <= cfg_lsb_first;
            div_l    <= cfg_div;
            len_l    <= len_eff;
            edge_cnt <= '0;
            busy_r   <= 1'b1;
            cs_n_r   <= !cfg_cs_en;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            sclk_r   <= ~sclk_r;
            edge_cnt <= edge_cnt + 1'b1;
            if (last_edge) begin
              state     <= ST_IDLE;
              busy_r    <= 1'b0;
              cs_n_r    <= 1'b1;
              done_r    <= 1'b1;
              rx_full_r <= 1'b1;
              rx_data_r <= rx_word;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sclk    = sclk_r;
  assign cs_n    = cs_n_r;
  assign busy    = busy_r;
  assign done    = done_r;
  assign rx_full = rx_full_r;
  assign rx_data = rx_data_r;
  assign tx_held = pend_valid;
  assign mosi    = mosi_bit;
endmodule

// File: rtl/spi_hs_master_chk.sv
module spi_hs_master_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic rx_full,
  input logic sclk,
  input logic cs_n,
  input logic cfg_cpol,
  input logic cfg_hs_en,
  input logic rdy_n
);
  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && $stable(cfg_cpol)) |-> (sclk == cfg_cpol));

  p_cs_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> cs_n);

  p_hold_off_r6: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && $past(cfg_hs_en)) |-> !$past(rdy_n, 3));

  p_done_full_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (rx_full && !busy));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_end_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> $fell(busy));
endmodule

bind spi_hs_master spi_hs_master_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .rx_full(rx_full),
  .sclk(sclk), .cs_n(cs_n), .cfg_cpol(cfg_cpol), .cfg_hs_en(cfg_hs_en),
  .rdy_n(rdy_n)
);

// File: tb/spi_hs_master_test.sv
module spi_hs_master_test;
  localparam int WORD = 16;
  localparam int DIV_W = 8;
  localparam int LEN_W = 5;

  logic clk = 0, rst = 1;
  logic cfg_cpol = 0, cfg_cpha = 0, cfg_lsb_first = 0, cfg_hs_en = 0, cfg_cs_en = 1;
  logic [DIV_W-1:0] cfg_div = 1;
  logic [LEN_W-1:0] cfg_len = 8;
  logic wr_en = 0, rd_en = 0, miso = 0, rdy_n = 0;
  logic [WORD-1:0] wr_data = 0, rx_data;
  logic rx_full, done, busy, tx_held, sclk, mosi, cs_n;

  always #4 clk = ~clk;

  spi_hs_master uut (
    .clk(clk), .rst(rst), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_lsb_first(cfg_lsb_first), .cfg_hs_en(cfg_hs_en), .cfg_cs_en(cfg_cs_en),
    .cfg_div(cfg_div), .cfg_len(cfg_len), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rx_data(rx_data), .rx_full(rx_full), .done(done),
    .busy(busy), .tx_held(tx_held), .sclk(sclk), .mosi(mosi), .miso(miso),
    .cs_n(cs_n), .rdy_n(rdy_n)
  );

  typedef struct {
    logic [15:0] tx;
    logic [15:0] sw;
    int          len;
    bit          lsb;
    bit          cpol;
    bit          cpha;
    int          div;
  } item_t;

  item_t exp_q[$];
  int vecs = 0, errs = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int eff_len(input int raw);
    if (raw < 2) return 2;
    if (raw > 16) return 16;
    return raw;
  endfunction

  function automatic int bit_idx(input item_t it, input int k);
    return it.lsb ? k : (it.len - 1 - k);
  endfunction

  // driver: queue the expectation, then write the word
  task automatic send(input logic [15:0] tx, input logic [15:0] sw);
    item_t it;
    it.tx = tx; it.sw = sw; it.len = eff_len(int'(cfg_len));
    it.lsb = cfg_lsb_first; it.cpol = cfg_cpol; it.cpha = cfg_cpha; it.div = int'(cfg_div);
    exp_q.push_back(it);
    @(negedge clk); wr_en = 1; wr_data = tx;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_idle();
    while (busy || tx_held || exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // behavioural slave
  item_t cur;
  int k_out, k_in;
  logic [15:0] cap;
  bit xfer_on = 0;

  always @(posedge busy) begin
    cur = exp_q[0];
    k_out = 0; k_in = 0; cap = 0; xfer_on = 1;
    if (!cur.cpha) begin
      miso = cur.sw[bit_idx(cur, 0)];
      k_out = 1;
    end
  end

  always @(sclk) begin
    #1;
    if (xfer_on) begin
      if ((sclk != cur.cpol) == !cur.cpha) begin
        cap[bit_idx(cur, k_in)] = mosi;
        k_in++;
        if (k_in == cur.len) xfer_on = 0;
      end else if (k_out < cur.len) begin
        miso = cur.sw[bit_idx(cur, k_out)];
        k_out++;
      end
    end
  end

  // monitor: duration and data compare at done
  int cyc = 0;
  always @(negedge clk) begin
    if (busy) cyc++;
    if (done) begin
      item_t it;
      logic [15:0] m;
      it = exp_q.pop_front();
      m = 16'((17'd1 << it.len) - 1);
      chk(rx_data == (it.sw & m), "R2/R4/R5 rx_data", rx_data, it.sw & m);
      chk(cap == (it.tx & m), "R2/R4/R5 mosi word", cap, it.tx & m);
      chk(cyc == 2 * it.len * (it.div + 1), "R3 duration", cyc, 2 * it.len * (it.div + 1));
      chk(rx_full === 1'b1, "R8 rx_full on done", rx_full, 1);
      chk(sclk === it.cpol, "R3 sclk idle", sclk, it.cpol);
      cyc = 0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk(busy == 0 && done == 0 && rx_full == 0 && tx_held == 0, "R1 flags", {busy, done, rx_full, tx_held}, 0);
    chk(cs_n == 1 && sclk == cfg_cpol, "R1 pins", {cs_n, sclk}, 2'b10);

    // R11 start latency
    cfg_len = 8; cfg_div = 1;
    exp_q.push_back('{tx:16'h00A5, sw:16'h003C, len:8, lsb:0, cpol:0, cpha:0, div:1});
    @(negedge clk); wr_en = 1; wr_data = 16'h00A5;
    @(negedge clk); wr_en = 0;
    chk(busy == 0 && tx_held == 1, "R11 busy before", busy, 0);
    @(negedge clk);
    chk(busy == 1 && cs_n == 0, "R11 busy after w+1 / R10 cs low", {busy, cs_n}, 2'b10);
    wait_idle();
    rd_en = 1; @(negedge clk); rd_en = 0;
    chk(rx_full == 0, "R8 rd_en clears", rx_full, 0);

    // R2 four modes
    for (int md = 0; md < 4; md++) begin
      cfg_cpol = md[1]; cfg_cpha = md[0]; cfg_div = DIV_W'(md);
      repeat (2) @(negedge clk);
      send(16'h00C3 ^ 16'(md * 17), 16'h005A + 16'(md));
      wait_idle();
    end

    // R4 lengths and R5 order
    cfg_cpol = 0; cfg_cpha = 1; cfg_div = 0;
    cfg_len = 16; send(16'hBEEF, 16'h1234); wait_idle();
    cfg_len = 2;  send(16'hFFFE, 16'hFFF1); wait_idle();
    cfg_len = 0;  send(16'h0001, 16'h0002); wait_idle();
    cfg_len = 31; send(16'hA1B2, 16'hC3D4); wait_idle();
    cfg_lsb_first = 1;
    cfg_len = 5;  send(16'h0013, 16'h0006); wait_idle();
    cfg_cpha = 0; cfg_len = 12; send(16'h0ABC, 16'h0123); wait_idle();
    cfg_lsb_first = 0;

    // R9 held word, overwrite
    cfg_len = 8; cfg_div = 2;
    send(16'h0011, 16'h0022);
    @(negedge clk);
    chk(busy == 1, "R9 first running", busy, 1);
    exp_q.push_back('{tx:16'h0077, sw:16'h0088, len:8, lsb:0, cpol:0, cpha:0, div:2});
    @(negedge clk); wr_en = 1; wr_data = 16'h0055;
    @(negedge clk); wr_data = 16'h0077;
    @(negedge clk); wr_en = 0;
    chk(tx_held == 1, "R9 tx_held", tx_held, 1);
    wait_idle();

    // R10 cs disabled
    cfg_cs_en = 0;
    send(16'h0099, 16'h0066);
    @(negedge clk);
    chk(busy == 1 && cs_n == 1, "R10 cs_n high when disabled", {busy, cs_n}, 2'b11);
    wait_idle();
    cfg_cs_en = 1;

    // R7 handshake off ignores rdy_n
    rdy_n = 1;
    send(16'h0033, 16'h00CC);
    @(negedge clk);
    chk(busy == 1, "R7 rdy_n ignored", busy, 1);
    wait_idle();

    // R6 handshake on
    cfg_hs_en = 1;
    send(16'h00F0, 16'h000F);
    repeat (10) @(negedge clk);
    chk(busy == 0 && tx_held == 1, "R6 held off", {busy, tx_held}, 2'b01);
    rdy_n = 0;
    @(negedge clk); chk(busy == 0, "R6 edge1", busy, 0);
    @(negedge clk); chk(busy == 0, "R6 edge2", busy, 0);
    @(negedge clk); chk(busy == 1, "R6 edge3", busy, 1);
    wait_idle();
    cfg_hs_en = 0;

    // R8 set beats clear
    send(16'h0044, 16'h00BB);
    while (!busy) @(negedge clk);
    rd_en = 1;
    while (!done) @(negedge clk);
    @(negedge clk); rd_en = 0;
    chk(rx_full == 0, "R8 cleared after", rx_full, 0);
    wait_idle();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule